// File: doc/BRIEF.md
# Host bus takeover and suspend controller

This block sits next to one processor that owns a shared external bus. It lets an external host take that bus over with a request/grant handshake. It also lets outside logic force the bus outputs to float with a suspend request. Tri-state is modelled as a single enable, `bus_oe_o`, which covers the address, data, select and strobe groups together. Each local core access to the bus lasts a fixed number of cycles. A suspend request stalls an access that is waiting to start and freezes one that is already running. In both cases the access completes only after the suspend is withdrawn.

The block also drives a host-side ready line, used to insert wait states while the host reads or writes internal memory. That line is driven only while the host request and this processor's own chip select are both asserted. By default it behaves as an open-drain output. A static configuration input switches it to active drive. All host-side inputs are asynchronous and go through a two-flop synchronizer.

Top module: `host_bus_ctrl`

## Requirements
- R1: During and right after reset the outputs are idle: `host_grant_no`=1, `bus_oe_o`=1, `core_ack_o`=0, `host_rdy_o`=1, `host_rdy_oe_o`=0.
- R2: `host_req_ni`, `suspend_ni` and `cs_ni` are active low and asynchronous. Each passes through two flops, so a level applied before clock edge n is seen by the control logic after edge n+1.
- R3: While the synchronized suspend is asserted, `bus_oe_o` is 0. Suspend applied before edge n floats the bus from edge n+1 onward.
- R4: A core access holds the bus for ACC_LEN cycles and then pulses `core_ack_o`. It does not start and does not advance while the synchronized suspend is asserted. `core_stall_o` equals `core_req_i` and not `core_ack_o`.
- R5: Host takeover from an idle bus follows a fixed order. One edge after the synchronized request is seen, `bus_oe_o` falls. One edge later, `host_grant_no` falls.
- R6: The bus is not floated for the host until the edge after the edge that completes an in-flight core access. No access is cut short.
- R7: `host_grant_no` stays 0 for as long as the synchronized host request stays asserted.
- R8: When the host request is removed, `host_grant_no` returns to 1 one edge after the removal is synchronized. `bus_oe_o` returns to 1 one edge after that.
- R9: A host request that is already synchronized takes priority over a core access that has not started. The core access starts only after the bus has been handed back.
- R10: The processor is selected when `cs_ni[self_id_i]`=0 and `host_req_ni`=0, both as seen after synchronization. The other chip-select bits are ignored. Once selected, `host_rdy_o` is 0 for RDY_WAIT cycles and then 1.
- R11: With `rdy_push_i`=1, `host_rdy_oe_o` is 1 for the whole time the processor is selected. With `rdy_push_i`=0 (open drain), `host_rdy_oe_o` is 1 only while `host_rdy_o` is 0.
- R12: While the processor is not selected, `host_rdy_oe_o`=0 and `host_rdy_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_req_ni | input | 1 | Host bus request, active low, asynchronous |
| suspend_ni | input | 1 | Suspend request that floats the bus, active low, asynchronous |
| cs_ni | input | N_CS | Per-processor chip selects from the host, active low |
| self_id_i | input | $clog2(N_CS) | Index of this processor's chip select (static) |
| rdy_push_i | input | 1 | 1: ready line is actively driven; 0: open drain |
| core_req_i | input | 1 | Core has an external access pending |
| host_grant_no | output | 1 | Host bus grant, active low |
| bus_oe_o | output | 1 | Output enable for address, data, select and strobe lines |
| core_stall_o | output | 1 | Core must wait |
| core_ack_o | output | 1 | Core access completes this cycle |
| host_rdy_o | output | 1 | Ready value toward the host (0 = wait state) |
| host_rdy_oe_o | output | 1 | Driver enable for the ready line |

## Verification
A wrong takeover state appears at the grant and bus-enable pins. It shows up either as grant asserted while the bus is still enabled, or as the bus enabled again before grant has been released. Either error appears within one cycle of the faulty transition. A wrong access counter moves the cycle in which `core_ack_o` appears. That cycle is compared exactly against sweeps of suspend start time, suspend length and host request time. A wrong ready counter or a wrong select decode appears at `host_rdy_o` and `host_rdy_oe_o` in the first cycles after selection. These are swept over every chip-select pattern, every processor index and both drive modes.

// File: rtl/hbc_pkg.sv
package hbc_pkg;
  typedef enum logic [1:0] {
    HB_OWN     = 2'd0,
    HB_FLOAT   = 2'd1,
    HB_GRANT   = 2'd2,
    HB_RESTORE = 2'd3
  } hb_state_e;
endpackage

// File: rtl/hbc_sync.sv
module hbc_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  // active-low inputs: reset to deasserted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '1;
      s2_q <= '1;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/hbc_grant_fsm.sv
module hbc_grant_fsm
  import hbc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic busy_i,
  output logic grant_no,
  output logic float_o
);
  hb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HB_OWN:     if (req_i && !busy_i) state_d = HB_FLOAT;
      HB_FLOAT:   state_d = req_i ? HB_GRANT : HB_OWN;
      HB_GRANT:   if (!req_i) state_d = HB_RESTORE;
      HB_RESTORE: state_d = HB_OWN;
      default:    state_d = HB_OWN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= HB_OWN;
    else         state_q <= state_d;
  end

  assign grant_no = (state_q != HB_GRANT);
  assign float_o  = (state_q != HB_OWN);
endmodule

// File: rtl/hbc_access.sv
module hbc_access #(
  parameter int ACC_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic core_req_i,
  input  logic bus_free_i,
  input  logic susp_i,
  output logic busy_o,
  output logic ack_o
);
  localparam int CW = (ACC_LEN > 1) ? $clog2(ACC_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(ACC_LEN - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (core_req_i && bus_free_i && !susp_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (!susp_i) begin
      // suspend freezes an access in flight
      if (cnt_q == LAST) busy_q <= 1'b0;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign ack_o  = busy_q && !susp_i && (cnt_q == LAST);
endmodule

// File: rtl/hbc_ready.sv
module hbc_ready #(
  parameter int RDY_WAIT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic push_i,
  output logic rdy_o,
  output logic rdy_oe_o
);
  localparam int WCW = $clog2(RDY_WAIT + 1);
  localparam logic [WCW-1:0] WMAX = WCW'(RDY_WAIT);

  logic [WCW-1:0] cnt_q;
  logic           done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!sel_i)        cnt_q <= '0;
    else if (cnt_q != WMAX) cnt_q <= cnt_q + 1'b1;
  end

  assign done     = (cnt_q == WMAX);
  assign rdy_o    = !sel_i || done;
  assign rdy_oe_o = sel_i && (push_i || !done);
endmodule

// File: rtl/host_bus_ctrl.sv
module host_bus_ctrl #(
  parameter int N_CS     = 4,
  parameter int ACC_LEN  = 3,
  parameter int RDY_WAIT = 2,
  localparam int IDW     = (N_CS > 1) ? $clog2(N_CS) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            host_req_ni,
  input  logic            suspend_ni,
  input  logic [N_CS-1:0] cs_ni,
  input  logic [IDW-1:0]  self_id_i,
  input  logic            rdy_push_i,
  input  logic            core_req_i,
  output logic            host_grant_no,
  output logic            bus_oe_o,
  output logic            core_stall_o,
  output logic            core_ack_o,
  output logic            host_rdy_o,
  output logic            host_rdy_oe_o
);
  localparam int SW = N_CS + 2;

  logic [SW-1:0]   sync_q;
  logic [N_CS-1:0] cs_s;
  logic            req_s, susp_s, sel_s;
  logic            acc_busy, floated;

  hbc_sync #(.W(SW)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({host_req_ni, suspend_ni, cs_ni}),
    .q_o    (sync_q)
  );

  assign req_s  = !sync_q[N_CS+1];
  assign susp_s = !sync_q[N_CS];
  assign cs_s   = ~sync_q[N_CS-1:0];
  assign sel_s  = cs_s[self_id_i] && req_s;

  hbc_grant_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_s),
    .busy_i   (acc_busy),
    .grant_no (host_grant_no),
    .float_o  (floated)
  );

  hbc_access #(.ACC_LEN(ACC_LEN)) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .core_req_i (core_req_i),
    .bus_free_i (!floated && !req_s),
    .susp_i     (susp_s),
    .busy_o     (acc_busy),
    .ack_o      (core_ack_o)
  );

  hbc_ready #(.RDY_WAIT(RDY_WAIT)) u_rdy (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (sel_s),
    .push_i   (rdy_push_i),
    .rdy_o    (host_rdy_o),
    .rdy_oe_o (host_rdy_oe_o)
  );

  assign bus_oe_o     = !floated && !susp_s;
  assign core_stall_o = core_req_i && !core_ack_o;
endmodule

// File: rtl/host_bus_ctrl_chk.sv
module host_bus_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic host_grant_no,
  input logic bus_oe_o,
  input logic core_ack_o,
  input logic host_rdy_o,
  input logic host_rdy_oe_o,
  input logic rdy_push_i,
  input logic req_s,
  input logic susp_s,
  input logic sel_s,
  input logic acc_busy
);
  // R5
  grant_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_grant_no |-> !bus_oe_o);

  // R3
  susp_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_s |-> !bus_oe_o);

  // R4
  susp_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_ack_o |-> !susp_s);

  // R6
  grant_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(host_grant_no) |-> (!acc_busy && !$past(core_ack_o)));

  // R7
  grant_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_grant_no && req_s) |=> !host_grant_no);

  // R8
  release_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(host_grant_no) |-> !bus_oe_o);

  // R8
  restore_late_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_oe_o) |-> $past(host_grant_no));

  // R9
  host_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_s && !acc_busy) |=> !acc_busy);

  // R12
  rdy_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_s |-> (host_rdy_o && !host_rdy_oe_o));

  // R11
  rdy_od_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdy_push_i && host_rdy_oe_o) |-> !host_rdy_o);

  // R11
  rdy_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_push_i && sel_s) |-> host_rdy_oe_o);
endmodule

bind host_bus_ctrl host_bus_ctrl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .host_grant_no (host_grant_no),
  .bus_oe_o      (bus_oe_o),
  .core_ack_o    (core_ack_o),
  .host_rdy_o    (host_rdy_o),
  .host_rdy_oe_o (host_rdy_oe_o),
  .rdy_push_i    (rdy_push_i),
  .req_s         (req_s),
  .susp_s        (susp_s),
  .sel_s         (sel_s),
  .acc_busy      (acc_busy)
);

// File: tb/host_bus_ctrl_tb.sv
`timescale 1ns/1ps
module host_bus_ctrl_tb;
  localparam int N_CS = 4;
  localparam int ACC_LEN = 3;
  localparam int RDY_WAIT = 2;
  localparam int IDW = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic host_req_ni = 1'b1, suspend_ni = 1'b1;
  logic [N_CS-1:0] cs_ni = '1;
  logic [IDW-1:0] self_id_i = '0;
  logic rdy_push_i = 1'b0, core_req_i = 1'b0;
  logic host_grant_no, bus_oe_o, core_stall_o, core_ack_o, host_rdy_o, host_rdy_oe_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  host_bus_ctrl #(.N_CS(N_CS), .ACC_LEN(ACC_LEN), .RDY_WAIT(RDY_WAIT)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .host_req_ni(host_req_ni), .suspend_ni(suspend_ni),
    .cs_ni(cs_ni), .self_id_i(self_id_i), .rdy_push_i(rdy_push_i), .core_req_i(core_req_i),
    .host_grant_no(host_grant_no), .bus_oe_o(bus_oe_o), .core_stall_o(core_stall_o),
    .core_ack_o(core_ack_o), .host_rdy_o(host_rdy_o), .host_rdy_oe_o(host_rdy_oe_o)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string rq, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic settle();
    host_req_ni = 1'b1; suspend_ni = 1'b1; cs_ni = '1; core_req_i = 1'b0;
    repeat (6) tick();
  endtask

  initial begin
    repeat (3) tick();
    check("R1 grant in reset", host_grant_no, 1);
    check("R1 oe in reset", bus_oe_o, 1);
    check("R1 rdy_oe in reset", host_rdy_oe_o, 0);
    rst_ni = 1'b1;
    tick();
    check("R1 grant", host_grant_no, 1);
    check("R1 oe", bus_oe_o, 1);
    check("R1 ack", core_ack_o, 0);
    check("R1 rdy", host_rdy_o, 1);
    check("R1 rdy_oe", host_rdy_oe_o, 0);

    // R3 R4 suspend sweep over start time and length
    for (int d = 0; d <= ACC_LEN + 1; d++) begin
      for (int h = 1; h <= 3; h++) begin
        int t, got, oe_bad, st_bad, exp_t;
        t = 0; got = 0; oe_bad = 0; st_bad = 0;
        core_req_i = 1'b1;
        for (int s = 0; s < 40 && got == 0; s++) begin
          suspend_ni = !(t >= d && t < d + h);
          tick(); t++;
          if (t >= d + 2 && t <= d + h + 1 && bus_oe_o) oe_bad = 1;
          if (core_ack_o) begin got = t; core_req_i = 1'b0; end
          else if (!core_stall_o) st_bad = 1;
        end
        exp_t = (d + 2 <= ACC_LEN) ? ACC_LEN + h : ACC_LEN;
        check("R4 ack cycle under suspend", got, exp_t);
        check("R3 bus floated while suspended", oe_bad, 0);
        check("R4 stall until ack", st_bad, 0);
        settle();
      end
    end

    // R4 access requested while already suspended
    begin
      int t, got, bad;
      suspend_ni = 1'b0;
      repeat (3) tick();
      check("R3 oe low under suspend", bus_oe_o, 0);
      core_req_i = 1'b1; bad = 0;
      repeat (5) begin tick(); if (core_ack_o || !core_stall_o) bad = 1; end
      check("R4 no progress while suspended", bad, 0);
      suspend_ni = 1'b1; t = 0; got = 0;
      for (int s = 0; s < 30 && got == 0; s++) begin
        tick(); t++;
        if (core_ack_o) begin got = t; core_req_i = 1'b0; end
      end
      check("R4 ack after release", got, ACC_LEN + 2);
      settle();
    end

    // R2 R5 R7 R8 idle takeover and release
    host_req_ni = 1'b0;
    repeat (2) tick();
    check("R2 request not yet acted on", bus_oe_o, 1);
    tick();
    check("R5 float first", bus_oe_o, 0);
    check("R5 grant not yet", host_grant_no, 1);
    tick();
    check("R5 grant", host_grant_no, 0);
    begin
      int bad = 0;
      repeat (6) begin tick(); if (host_grant_no || bus_oe_o) bad = 1; end
      check("R7 grant held", bad, 0);
    end
    host_req_ni = 1'b1;
    repeat (2) tick();
    check("R2 R8 grant held through sync", host_grant_no, 0);
    tick();
    check("R8 grant released", host_grant_no, 1);
    check("R8 oe still off", bus_oe_o, 0);
    tick();
    check("R8 oe restored", bus_oe_o, 1);
    settle();

    // R6 host request during an access, swept over arrival time
    for (int k = 0; k <= ACC_LEN + 2; k++) begin
      int t, f_oe, f_g, ack_t, exp_f;
      t = 0; f_oe = 0; f_g = 0; ack_t = 0;
      core_req_i = 1'b1;
      for (int s = 0; s < 30; s++) begin
        host_req_ni = !(t >= k);
        tick(); t++;
        if (core_ack_o && ack_t == 0) begin ack_t = t; core_req_i = 1'b0; end
        if (!bus_oe_o && f_oe == 0) f_oe = t;
        if (!host_grant_no && f_g == 0) f_g = t;
      end
      exp_f = ((k + 2 > ACC_LEN + 1) ? k + 2 : ACC_LEN + 1) + 1;
      check("R6 access completes", ack_t, ACC_LEN);
      check("R6 float cycle", f_oe, exp_f);
      check("R6 grant cycle", f_g, exp_f + 1);
      settle();
    end

    // R9 host wins over a pending core access
    begin
      int t, got, bad;
      host_req_ni = 1'b0;
      repeat (2) tick();
      core_req_i = 1'b1; bad = 0;
      for (int s = 0; s < 6; s++) begin
        tick();
        if (core_ack_o || !core_stall_o) bad = 1;
      end
      check("R9 core held off", bad, 0);
      check("R9 host granted", host_grant_no, 0);
      host_req_ni = 1'b1; t = 0; got = 0;
      for (int s = 0; s < 30 && got == 0; s++) begin
        tick(); t++;
        if (core_ack_o) begin got = t; core_req_i = 1'b0; end
      end
      check("R9 core ack after handback", got, 4 + ACC_LEN);
      settle();
    end

    // R10 R11 R12 ready sweep: id, drive mode, request, every cs pattern
    for (int id = 0; id < N_CS; id++)
      for (int pm = 0; pm < 2; pm++)
        for (int rq = 0; rq < 2; rq++)
          for (int cs = 0; cs < (1 << N_CS); cs++) begin
            bit sel;
            self_id_i = IDW'(id);
            rdy_push_i = pm[0];
            cs_ni = N_CS'(cs);
            host_req_ni = !rq[0];
            sel = rq[0] && !cs[id];
            for (int t = 1; t <= 3 + RDY_WAIT; t++) begin
              int er, eo;
              tick();
              er = (!(sel && t >= 2) || t >= 2 + RDY_WAIT) ? 1 : 0;
              eo = (sel && t >= 2 && (pm == 1 || t < 2 + RDY_WAIT)) ? 1 : 0;
              check(sel ? "R10 ready value" : "R12 ready idle", host_rdy_o, er);
              check(sel ? "R11 ready drive" : "R12 ready undriven", host_rdy_oe_o, eo);
            end
            settle();
          end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule